// File: doc/BRIEF.md
# Sync-Controlled Video Line Delay

This block delays a stream of 8-bit pixels by exactly one video line. It is the storage element that sits between successive rows of a two-dimensional image window: a chain of these delays gives a filter the pixels at the same horizontal position on the preceding lines. Every pixel clock the block reads the value held at the current address of a RAM line store and then overwrites that location with the incoming pixel. The value read out is the pixel that arrived at the same position on the previous line.

The length of a line is set in one of three ways, chosen by a 2-bit mode register.

- **Sync-timed mode.** The line length is the number of clocks for which the sync input stays low.
- **Programmed mode.** The line length is a programmed 10-bit end address, and counting starts when sync falls.
- **Free-running mode.** The address runs continuously and wraps at the programmed end address. This mode suits frame-store and line-scan systems, which have no flyback gaps.

Writes stop once the line store is full, so data never wraps around within a line. A delayed copy of the sync input leaves the block aligned with the output pixels. External logic uses it as the marker for valid output data and for writeback. The store is built from cascaded RAM banks, so deeper delays come from joining smaller stores.

Top module: `sync_line_delay`

## Requirements
- R1: The pixel on `pix_o` appears exactly 2 clocks after the pixel that `pix_i` accepted at the same address. It equals the value last written to that address, so on consecutive full lines the output is the previous line's pixel at the same position.
- R2: `del_sync_o` equals `sync_i` delayed by exactly 2 clocks.
- R3: In mode 0 (sync-timed), a high level on `sync_i` holds the write address at 0 and blocks writes. Each clock with `sync_i` low stores one pixel, at addresses 0, 1, 2, … in order.
- R4: In mode 0, a line longer than DEPTH pixels stores only its first DEPTH pixels. Pixels beyond that are discarded, and addresses 0 to DEPTH-1 keep the first DEPTH pixels of the line.
- R5: In mode 1 (programmed), a line stores pixels only at addresses 0 to L, where L is the programmed length value. For a line of N pixels (N even), L is N-1. Later pixels in the line are discarded.
- R6: A programmed length L of DEPTH or more acts as DEPTH-1 in modes 1 and 2.
- R7: In mode 2 (free-running), every clock with `sync_i` low writes a pixel, and the address wraps from L back to 0 with no gap. Within one low stretch, the output for a pixel is therefore the pixel accepted L+1 clocks earlier.
- R8: Mode 3 behaves exactly as mode 0.
- R9: The configuration port writes one register per clock when `cfg_we` is high. Address 0 loads length bits 7:0 from `cfg_wdata[7:0]`. Address 1 loads length bits 9:8 from `cfg_wdata[1:0]`. Address 2 loads the mode from `cfg_wdata[1:0]`. A write to address 3 changes nothing.
- R10: A low `rst_n` at a clock edge clears the sync delay pipeline, so `del_sync_o` is 0, and returns the address to 0. It also sets the mode to 0 and the length to 1023. RAM contents are left as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Horizontal sync / update window, high = blanking |
| pix_i | input | DATA_W | Incoming pixel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| pix_o | output | DATA_W | Pixel from the previous line at the same position |
| del_sync_o | output | 1 | Sync input delayed to match `pix_o` |

## Verification
The bench builds the block with DEPTH = 16 and BANK_DEPTH = 8. This makes a 16-pixel line store made of two cascaded banks, small enough to fill, overflow and wrap within a few dozen clocks. With these values, every address and the crossing between the two banks are exercised on each line. Lines longer than the store, programmed lengths below and above the store depth, and free-running wrap at a short length can all be swept in full. Each output pixel is compared against a value computed from its line number, its position and the configured mode.

// File: rtl/lnd_pkg.sv
// Package: shared mode encoding, configuration register map and length width
// for the sync-controlled line delay.
package lnd_pkg;

    // Width of the programmed line length register.
    localparam int LEN_W = 10;

    // Addressing modes; value 3 is decoded like the sync-timed mode.
    typedef enum logic [1:0] {
        LD_SYNC     = 2'd0,
        LD_PROG     = 2'd1,
        LD_FREE     = 2'd2,
        LD_SYNC_ALT = 2'd3
    } ld_mode_e;

    // Configuration register select values.
    localparam logic [1:0] CFG_LEN_LO = 2'd0;
    localparam logic [1:0] CFG_LEN_HI = 2'd1;
    localparam logic [1:0] CFG_MODE   = 2'd2;

endpackage

// File: rtl/lnd_cfg_regs.sv
// Configuration registers: the programmed line length (low byte + high bits)
// and the addressing mode. Assumes one write per strobe cycle; unmapped
// addresses are ignored.
module lnd_cfg_regs
    import lnd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [LEN_W-1:0] len_o,
    output ld_mode_e         mode_o
);

    // Register update on strobe, defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_o  <= '1;
            mode_o <= LD_SYNC;
        end else if (we) begin
            case (addr)
                CFG_LEN_LO: len_o[7:0]       <= wdata;
                CFG_LEN_HI: len_o[LEN_W-1:8] <= wdata[LEN_W-9:0];
                CFG_MODE:   mode_o           <= ld_mode_e'(wdata[1:0]);
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/lnd_addr_ctrl.sv
// Address sequencer: produces the line store address and write enable from
// the registered sync level and the selected mode. Assumes DEPTH <= 2**LEN_W
// and that sync has already been registered by the caller.
module lnd_addr_ctrl
    import lnd_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_q,
    input  ld_mode_e         mode,
    input  logic [LEN_W-1:0] len,
    output logic [AW-1:0]    addr,
    output logic             wen
);

    localparam logic [AW-1:0]    LAST_A = AW'(DEPTH - 1);
    localparam logic [LEN_W-1:0] LAST_L = LEN_W'(DEPTH - 1);

    logic [AW-1:0] len_eff;
    logic [AW-1:0] limit;
    logic          stop;
    logic          at_lim;
    logic          use_len;

    // Clamp the programmed length to the store depth and pick the end address.
    always_comb begin
        len_eff = (len > LAST_L) ? LAST_A : len[AW-1:0];
        use_len = (mode == LD_PROG) || (mode == LD_FREE);
        limit   = use_len ? len_eff : LAST_A;
        at_lim  = (addr == limit);
        wen     = !sync_q && ((mode == LD_FREE) || !stop);
    end

    // Address counter and end-of-line write inhibit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            stop <= 1'b0;
        end else if (sync_q) begin
            addr <= '0;
            stop <= 1'b0;
        end else if (mode == LD_FREE) begin
            addr <= at_lim ? '0 : addr + 1'b1;
            stop <= 1'b0;
        end else if (!stop) begin
            if (at_lim) stop <= 1'b1;
            else        addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/lnd_store.sv
// Line store: DEPTH entries built from cascaded BANK_DEPTH banks. Read of the
// old word and write of the new one happen at the same address in one clock;
// read data is registered (one cycle latency). Assumes power-of-two sizes.
module lnd_store #(
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 1024,
    parameter int BANK_DEPTH = 512,
    localparam int AW        = $clog2(DEPTH),
    localparam int NBANK     = DEPTH / BANK_DEPTH,
    localparam int BW        = $clog2(BANK_DEPTH),
    localparam int SW        = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic              wen,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [SW-1:0]                  sel;
    logic [SW-1:0]                  sel_q;
    logic [NBANK-1:0][DATA_W-1:0]   bank_rd;

    // Bank select comes from the upper address bits when banks are cascaded.
    generate
        if (NBANK > 1) begin : g_sel
            assign sel = addr[AW-1:BW];
        end else begin : g_one
            assign sel = '0;
        end
    endgenerate

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0] mem [BANK_DEPTH];
        logic [DATA_W-1:0] q;

        // Read-before-write on the shared row address.
        always_ff @(posedge clk) begin
            q <= mem[addr[BW-1:0]];
            if (wen && (sel == SW'(b))) mem[addr[BW-1:0]] <= wdata;
        end

        assign bank_rd[b] = q;
    end

    // Remember which bank was read to steer the output.
    always_ff @(posedge clk) begin
        sel_q <= sel;
    end

    assign rdata = bank_rd[sel_q];

endmodule

// File: rtl/sync_line_delay.sv
// Top: one-line video delay with sync-timed, programmed and free-running
// addressing. Registers sync and pixel, drives the line store, and outputs
// the sync level delayed by the same latency as the pixel path (2 clocks).
module sync_line_delay
    import lnd_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 1024,
    parameter int BANK_DEPTH = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [DATA_W-1:0] pix_i,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [DATA_W-1:0] pix_o,
    output logic              del_sync_o
);

    localparam int AW  = $clog2(DEPTH);
    localparam int LAT = 2;

    logic [LAT-1:0]    sync_pipe;
    logic              sync_q;
    logic [DATA_W-1:0] pix_q;
    logic [AW-1:0]     addr;
    logic              wen;
    ld_mode_e          mode;
    logic [LEN_W-1:0]  len;

    // Sync delay line: stage 0 feeds the sequencer, last stage is the output.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_pipe <= '0;
        else        sync_pipe <= {sync_pipe[LAT-2:0], sync_i};
    end

    // Pixel input register, aligned with sync stage 0.
    always_ff @(posedge clk) begin
        pix_q <= pix_i;
    end

    assign sync_q     = sync_pipe[0];
    assign del_sync_o = sync_pipe[LAT-1];

    lnd_cfg_regs u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .len_o  (len),
        .mode_o (mode)
    );

    lnd_addr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_q (sync_q),
        .mode   (mode),
        .len    (len),
        .addr   (addr),
        .wen    (wen)
    );

    lnd_store #(
        .DATA_W     (DATA_W),
        .DEPTH      (DEPTH),
        .BANK_DEPTH (BANK_DEPTH)
    ) u_store (
        .clk   (clk),
        .addr  (addr),
        .wen   (wen),
        .wdata (pix_q),
        .rdata (pix_o)
    );

endmodule

// File: rtl/lnd_chk.sv
// Checker for sync_line_delay: timing of the delayed sync, address sequencing
// per mode, overflow inhibit and mode register writes.
module lnd_chk #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_i,
    input logic          del_sync_o,
    input logic          sync_q,
    input logic [AW-1:0] addr,
    input logic          wen,
    input logic [1:0]    mode,
    input logic          cfg_we,
    input logic [1:0]    cfg_addr,
    input logic [1:0]    cfg_wdata
);

    logic [1:0] cyc;

    // Count clocks since reset so history-based checks start late enough.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R2
    delop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (del_sync_o == $past(sync_i, 2)));

    // R3
    addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |=> (addr == '0));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_q && wen && mode == 2'd0 && addr != AW'(DEPTH - 1))
        |=> (addr == $past(addr) + 1'b1));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && !sync_q && addr == AW'(DEPTH - 1))
        |=> (!wen || mode == 2'd2));

    // R7
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && wen)
        |=> ((addr == $past(addr) + 1'b1) || (addr == '0)));

    // R9
    mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd2) |=> (mode == $past(cfg_wdata)));

endmodule

bind sync_line_delay lnd_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sync_i),
    .del_sync_o (del_sync_o),
    .sync_q     (sync_q),
    .addr       (addr),
    .wen        (wen),
    .mode       (mode),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata[1:0])
);

// File: tb/sync_line_delay_test.sv
`timescale 1ns/1ps
// Bench: small store (16 entries, two banks); expected pixels come from a
// per-position record of what the requirements say must have been stored.
module sync_line_delay_test;

    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int BANK  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sync_i;
    logic [DW-1:0] pix_i;
    logic          cfg_we;
    logic [1:0]    cfg_addr;
    logic [7:0]    cfg_wdata;
    logic [DW-1:0] pix_o;
    logic          del_sync_o;

    always #2 clk = ~clk;

    sync_line_delay #(.DATA_W(DW), .DEPTH(DEPTH), .BANK_DEPTH(BANK)) uut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .pix_i(pix_i),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pix_o(pix_o), .del_sync_o(del_sync_o)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    int    ref_m [DEPTH];
    int    pos, mode_m, len_m, line_no;
    bit    stop;
    int    exp_v [2];
    int    sd [2];
    string cur_req;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lim_f();
        if (mode_m == 1 || mode_m == 2) return (len_m > DEPTH - 1) ? DEPTH - 1 : len_m;
        return DEPTH - 1;
    endfunction

    function automatic int val(int n, int k);
        return (n * 37 + k * 5 + mode_m * 11) & 255;
    endfunction

    // One clock: check outputs due now, then drive the next input.
    task automatic step(bit s, int p);
        int lim;
        @(negedge clk);
        if (exp_v[1] >= 0) check(cur_req, int'(pix_o), exp_v[1]);
        if (sd[1] >= 0)    check("R2", int'(del_sync_o), sd[1]);
        exp_v[1] = exp_v[0];
        sd[1] = sd[0];
        sd[0] = s;
        sync_i = s;
        pix_i = p[DW-1:0];
        lim = lim_f();
        if (s) begin
            pos = 0; stop = 0; exp_v[0] = -1;
        end else if (mode_m == 2) begin
            exp_v[0] = ref_m[pos];
            ref_m[pos] = p & 255;
            pos = (pos == lim) ? 0 : pos + 1;
        end else begin
            exp_v[0] = ref_m[pos];
            if (!stop) begin
                ref_m[pos] = p & 255;
                if (pos == lim) stop = 1; else pos++;
            end
        end
    endtask

    task automatic line(int len);
        for (int k = 0; k < len; k++) step(1'b0, val(line_no, k));
        for (int k = 0; k < 3; k++) step(1'b1, 0);
        line_no++;
    endtask

    // Register write; the model follows only the map stated in R9.
    task automatic cfg(logic [1:0] a, logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        step(1'b1, 0);
        cfg_we = 1'b0;
        step(1'b1, 0);
        case (a)
            2'd0: len_m = (len_m & 32'h300) | int'(d);
            2'd1: len_m = (len_m & 32'h0FF) | (int'(d[1:0]) << 8);
            2'd2: mode_m = int'(d[1:0]);
            default: ;
        endcase
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_m[i] = -1;
        exp_v[0] = -1; exp_v[1] = -1; sd[0] = -1; sd[1] = -1;
        pos = 0; stop = 0; mode_m = 0; len_m = 1023; line_no = 0;
        rst_n = 1'b0; sync_i = 1'b1; pix_i = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        // R10: pipeline cleared under reset even with sync held high
        check("R10", int'(del_sync_o), 0);
        rst_n = 1'b1;

        // R1 R3 R10: sync-timed lines of varying length
        cur_req = "R1";
        line(10); line(10);
        cur_req = "R3";
        line(7); line(12); line(12);

        // R4: overflowing line, then readback
        cur_req = "R4";
        line(20); line(16); line(16);

        // R5: programmed length 9 (10 pixels)
        cfg(2'd0, 8'd9); cfg(2'd1, 8'd0); cfg(2'd2, 8'd1);
        cur_req = "R5";
        line(14); line(14); line(6); line(14);

        // R6: length 260 clamps to 15
        cfg(2'd1, 8'd1); cfg(2'd0, 8'd4);
        cur_req = "R6";
        line(20); line(16); line(16);

        // R7: free-running with wrap at 5
        cfg(2'd1, 8'd0); cfg(2'd0, 8'd5); cfg(2'd2, 8'd2);
        cur_req = "R7";
        line(30); line(12);

        // R9: address 3 write must not alter mode or length
        cfg(2'd3, 8'd1);
        cur_req = "R9";
        line(14); line(9);

        // R8: mode 3 acts as sync-timed, including overflow
        cfg(2'd2, 8'd3);
        cur_req = "R8";
        line(20); line(16); line(16);

        step(1'b1, 0); step(1'b1, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule